// File: doc/BRIEF.md
# Tick-Counting Watchdog with Control Register

This block watches for a stalled program. A clock-timer prescaler supplies a one-second tick as a one-cycle enable in the system clock domain. The block counts these ticks. If software does not service it, it raises a one-cycle initial-reset request for the CPU on the fourth tick after the last service. The tick phase at service time is unknown, so the request arrives 3 to 4 seconds after that service.

Software reaches the block through one nibble-wide control register at address 0xF76. Writing a 1 to bit 0 services the watchdog. Writing a 1 to bit 1 sends a one-cycle reset strobe to the shared clock timer. That reset costs one watchdog count, so software should service the watchdog right after it when needed.

The block has no halt or sleep input. Counting therefore goes on while the CPU is halted. The register reads back as zero.

Top module: `wdt_tick_guard`

## Requirements
- R1: While reset is active, and in the first cycle after it, `wdt_fire_o`, `tmr_clr_o` and `bus_rdata` are 0. Reset also clears the tick count.
- R2: Each cycle with `tick_1hz` high adds one to a 2-bit count. The fourth count after reset, after a service or after a timeout drives `wdt_fire_o` high for exactly one cycle, the cycle after that tick. The count then starts again from zero.
- R3: A write (`bus_wr`=1) to address 0xF76 with data bit 0 = 1 sets the count to zero. The same write with data bit 0 = 0 leaves the count unchanged.
- R4: When a service write and a tick arrive in the same cycle, the service wins and the count ends at zero.
- R5: A write to 0xF76 with data bit 1 = 1 drives `tmr_clr_o` high for exactly the next cycle. The same write adds one count.
  - If a tick arrives in the same cycle, the total added is still one.
  - If data bit 0 is also 1, the service wins and the count is zero, but the strobe is still issued.
- R6: A write to any address other than 0xF76 changes neither the count nor `tmr_clr_o`.
- R7: A read (`bus_rd`=1) of 0xF76 returns 0 on `bus_rdata` in the following cycle. This holds for bits 0 to 3, including the unused bits 2 and 3. `bus_rdata` is 0 at all other times.
- R8: Counting depends only on ticks and register writes, and nothing else gates it. Servicing after every second tick keeps `wdt_fire_o` low indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle enable once per second from the clock timer |
| bus_addr | input | 12 | Nibble I/O address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 4 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 4 | Read data, valid the cycle after `bus_rd` |
| tmr_clr_o | output | 1 | One-cycle clock-timer reset strobe |
| wdt_fire_o | output | 1 | One-cycle initial-reset request |

## Verification
Every result of this block is registered once, so each result is due one cycle after the clock edge that samples its stimulus:
- `wdt_fire_o`, in the cycle after the fourth counted edge;
- `tmr_clr_o`, in the cycle after the write;
- `bus_rdata`, in the cycle after the read strobe.

The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge, exactly where each output is due. Internal count values are never read. They are inferred from when the timeout pulse appears after a known number of ticks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned BUS_AW   = 12;
    localparam int unsigned BUS_DW   = 4;
    localparam int unsigned CNT_W    = 2;
    localparam int unsigned SVC_BIT  = 0;
    localparam int unsigned TCLR_BIT = 1;
    localparam logic [BUS_AW-1:0] CTRL_ADDR = 12'hF76;
endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
    import wdt_pkg::*;
#(
    parameter int unsigned AW = BUS_AW,
    parameter int unsigned DW = BUS_DW,
    parameter logic [AW-1:0] ADDR = CTRL_ADDR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_i,
    output logic          svc_o,
    output logic          bump_o,
    output logic          tclr_o,
    output logic [DW-1:0] rdata_o
);
    // write-only bits: every bit of the register reads back as zero
    localparam logic [DW-1:0] READ_VIEW = '0;

    typedef struct packed {
        logic          tclr;
        logic [DW-1:0] rdata;
    } rif_t;

    rif_t s_d, s_q;
    logic hit;
    logic unused_wdata;

    assign hit          = (addr_i == ADDR);
    assign svc_o        = wr_i && hit && wdata_i[SVC_BIT];
    assign bump_o       = wr_i && hit && wdata_i[TCLR_BIT];
    assign unused_wdata = ^wdata_i;

    always_comb begin
        s_d       = s_q;
        s_d.tclr  = bump_o;
        s_d.rdata = (rd_i && hit) ? READ_VIEW : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tclr_o  = s_q.tclr;
    assign rdata_o = s_q.rdata;
endmodule

// File: rtl/wdt_count.sv
module wdt_count
    import wdt_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          bump_i,
    input  logic          svc_i,
    output logic [CW-1:0] cnt_o,
    output logic          fire_o
);
    localparam logic [CW-1:0] LAST = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fire;
    } cnt_t;

    cnt_t s_d, s_q;
    logic step;

    // a tick and a timer clear in one cycle count once
    assign step = tick_i || bump_i;

    always_comb begin
        s_d      = s_q;
        s_d.fire = 1'b0;
        if (svc_i) begin
            s_d.cnt = '0;
        end else if (step) begin
            if (s_q.cnt == LAST) begin
                s_d.cnt  = '0;
                s_d.fire = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o  = s_q.cnt;
    assign fire_o = s_q.fire;
endmodule

// File: rtl/wdt_tick_guard.sv
module wdt_tick_guard
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              tmr_clr_o,
    output logic              wdt_fire_o
);
    logic             svc_w;
    logic             bump_w;
    logic [CNT_W-1:0] cnt_w;

    wdt_regif #(.AW(BUS_AW), .DW(BUS_DW), .ADDR(CTRL_ADDR)) i_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wr_i    (bus_wr),
        .wdata_i (bus_wdata),
        .rd_i    (bus_rd),
        .svc_o   (svc_w),
        .bump_o  (bump_w),
        .tclr_o  (tmr_clr_o),
        .rdata_o (bus_rdata)
    );

    wdt_count #(.CW(CNT_W)) i_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_1hz),
        .bump_i (bump_w),
        .svc_i  (svc_w),
        .cnt_o  (cnt_w),
        .fire_o (wdt_fire_o)
    );
endmodule

// File: rtl/wdt_tick_guard_chk.sv
module wdt_tick_guard_chk
    import wdt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1hz,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic [BUS_DW-1:0] bus_rdata,
    input logic              tmr_clr_o,
    input logic              wdt_fire_o,
    input logic [CNT_W-1:0]  cnt
);
    logic hit_wr;
    assign hit_wr = bus_wr && (bus_addr == CTRL_ADDR);

    // R2
    fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_fire_o |=> !wdt_fire_o);

    // R2
    fire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_fire_o |-> $past(tick_1hz || (hit_wr && bus_wdata[TCLR_BIT])));

    // R3
    svc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr && bus_wdata[SVC_BIT]) |=> (cnt == '0 && !wdt_fire_o));

    // R5
    tclr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr && bus_wdata[TCLR_BIT]) |=> tmr_clr_o);

    // R6
    tclr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clr_o |-> $past(hit_wr && bus_wdata[TCLR_BIT]));

    // R6
    foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit_wr && !tick_1hz) |=> $stable(cnt));

    // R7
    rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata == '0);
endmodule

bind wdt_tick_guard wdt_tick_guard_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1hz   (tick_1hz),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tmr_clr_o  (tmr_clr_o),
    .wdt_fire_o (wdt_fire_o),
    .cnt        (cnt_w)
);

// File: tb/test_wdt_tick_guard.sv
module test_wdt_tick_guard;
    localparam int CLK_NS = 10;
    localparam logic [11:0] CTRL = 12'hF76;
    localparam int NVEC = 29;
    // [7] tick [6] write [5:2] wdata [1] expected fire [0] expected timer strobe
    localparam logic [7:0] VEC [0:NVEC-1] = '{
        8'b10000000, 8'b10000000, 8'b10000000, 8'b10000010, 8'b00000000,
        8'b10000000, 8'b01000100, 8'b10000000, 8'b10000000, 8'b10000000,
        8'b01000000, 8'b10000010, 8'b01001001, 8'b10000000, 8'b10000000,
        8'b10000010, 8'b11000100, 8'b10000000, 8'b10000000, 8'b10000000,
        8'b01001101, 8'b10000000, 8'b10000000, 8'b10000000, 8'b10000010,
        8'b11001001, 8'b10000000, 8'b10000000, 8'b10000010
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [11:0] addr = '0;
    logic        wr = 1'b0;
    logic [3:0]  wdata = '0;
    logic        rd = 1'b0;
    logic [3:0]  rdata;
    logic        tclr;
    logic        fire;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    wdt_tick_guard i_wdt_tick_guard (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .bus_addr(addr),
        .bus_wr(wr), .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata),
        .tmr_clr_o(tclr), .wdt_fire_o(fire)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // drive on a falling edge, pass one rising edge, return on the next falling edge
    task automatic cyc(input logic t, input logic w, input logic [11:0] a,
                       input logic [3:0] d, input logic r);
        tick = t; wr = w; addr = a; wdata = d; rd = r;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; wr = 1'b0; rd = 1'b0; wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog (all requirements) act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int fires;
        @(negedge clk);
        // R1: outputs during reset
        chk("R1 fire in reset", {3'b0, fire}, 4'h0);
        chk("R1 tclr in reset", {3'b0, tclr}, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata after reset", rdata, 4'h0);
        chk("R1 fire after reset", {3'b0, fire}, 4'h0);

        // table walk: R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            cyc(VEC[i][7], VEC[i][6], CTRL, VEC[i][5:2], 1'b0);
            chk($sformatf("R2/R3/R4/R5 fire row %0d", i), {3'b0, fire}, {3'b0, VEC[i][1]});
            chk($sformatf("R5 tclr row %0d", i), {3'b0, tclr}, {3'b0, VEC[i][0]});
        end

        // R6: foreign address write ignored
        for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, CTRL, 4'h0, 1'b0);
        cyc(1'b0, 1'b1, 12'hF75, 4'hF, 1'b0);
        chk("R6 no strobe from foreign write", {3'b0, tclr}, 4'h0);
        cyc(1'b1, 1'b0, CTRL, 4'h0, 1'b0);
        chk("R6 count kept past foreign write", {3'b0, fire}, 4'h1);

        // R7: read of the control register
        cyc(1'b0, 1'b1, CTRL, 4'hF, 1'b1);
        chk("R7 read data zero", rdata, 4'h0);
        cyc(1'b0, 1'b0, CTRL, 4'h0, 1'b1);
        chk("R7 read data zero again", rdata, 4'h0);

        // R1: reset mid-count clears the count
        for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, CTRL, 4'h0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, CTRL, 4'h0, 1'b0);
        chk("R1 count cleared by reset", {3'b0, fire}, 4'h0);
        cyc(1'b0, 1'b1, CTRL, 4'h1, 1'b0);

        // R8: service every second tick, ticks spaced 8 cycles apart
        fires = 0;
        for (int s = 1; s <= 24; s++) begin
            cyc(1'b1, 1'b0, CTRL, 4'h0, 1'b0);
            if (fire) fires++;
            for (int g = 0; g < 7; g++) begin
                cyc(1'b0, (s % 2 == 0) && g == 2, CTRL, 4'h1, 1'b0);
                if (fire) fires++;
            end
        end
        chk("R8 no timeout under periodic service", fires[3:0], 4'h0);
        fires = 0;
        for (int s = 0; s < 4; s++) begin
            cyc(1'b1, 1'b0, CTRL, 4'h0, 1'b0);
            if (fire) fires++;
            for (int g = 0; g < 7; g++) begin
                cyc(1'b0, 1'b0, CTRL, 4'h0, 1'b0);
                if (fire) fires++;
            end
        end
        chk("R8 R2 one timeout after service stops", fires[3:0], 4'h1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule